// File: doc/BRIEF.md
# Triggered Data Capture Port with Data-Available Marker

This block is one 16-channel capture port. It takes already debounced channel levels and copies them into a data register each time a capture strobe fires. The strobe comes from one of two sources. The first is an active-low external trigger pin, which is brought into the system clock domain and reduced to a single-cycle pulse on its falling edge. The second is an internal sample tick, nominally 1 MHz, made by dividing the 16 MHz system clock. A source-select bit from the command register picks between them.

Every capture raises a data-available marker. When interrupts are enabled, the marker drives the interrupt request. Software reads the data register by holding a read strobe for the length of the bus cycle, and the marker clears when that cycle ends. A capture that lands inside a read cycle is not lost. It is parked and applied once the read finishes. The marker is then held low for a short gap so that the control logic sees a fresh posting.

Moving the source from internal to external always wipes the marker. Any capture that arrives while the switch settles is thrown away.

Top module: `dav_capture_port`

## Requirements
- R1: While rst_ni is low and directly after its release, dav_o and irq_o are 0 and data_o is all zeros.
- R2: With src_ext_i = 0 (internal source), a capture happens once every TICK_DIV clocks, the first within TICK_DIV+1 clocks of reset release. Each capture loads data_o with din_i and sets dav_o.
- R3: With src_ext_i = 1, a falling edge on xtrig_ni that is set up before a rising clock edge causes dav_o to rise right after the third rising edge, counting that one. data_o then holds din_i as it was at that third edge.
- R4: The read cycle is the span of clocks with rd_i = 1. At the first rising edge after it with rd_i = 0, dav_o clears. data_o keeps its value when no capture was queued.
- R5: A capture during a read cycle leaves data_o and dav_o untouched until the cycle ends. dav_o then stays low for exactly GAP_CYCLES (2) clocks and rises again, with data_o holding the queued value. It stays set until the next read.
- R6: A 0 to 1 change of src_ext_i clears dav_o at the next rising edge. Captures are ignored for BLANK_CYCLES (4) clocks from that edge, and data_o is unchanged by them.
- R7: irq_o is 1 exactly when irq_en_i = 1 and dav_o = 1.
- R8: Holding xtrig_ni low gives a single capture. No further capture occurs until xtrig_ni goes high and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (16 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | NUM_CH | Debounced channel levels, synchronous to clk_i |
| xtrig_ni | input | 1 | External capture trigger, active low, asynchronous |
| src_ext_i | input | 1 | Capture source select: 0 internal tick, 1 external trigger |
| irq_en_i | input | 1 | Data-available interrupt enable |
| rd_i | input | 1 | Data register read strobe, high for the whole read cycle |
| data_o | output | NUM_CH | Captured data register |
| dav_o | output | 1 | Data-available marker |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after four risky cases. The first is a capture that lands inside a read. A design that overwrites the register mid-read would show corrupted data, and one that drops the capture would never re-post the marker. The second is the width of the low gap before the re-post: a design without a gap would keep dav_o high straight through, and an off-by-one counter would re-post a cycle early or late. The third is a trigger that falls just as the source flips to external. A design without blanking would post that capture instead of dropping it. The fourth is a trigger held low after a read. A level-sensitive detector would re-post the marker at once, where an edge detector stays quiet.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } cap_src_e;

endpackage

// File: rtl/dcp_trig_sync.sv
module dcp_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_ni,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], trig_ni};
      last_q <= sync_q[STAGES-1];
    end
  end

  // single-cycle pulse on the synchronized high-to-low transition
  assign fall_o = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/dcp_tick_gen.sv
module dcp_tick_gen #(
  parameter int DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/dcp_marker_ctl.sv
module dcp_marker_ctl #(
  parameter int W     = 16,
  parameter int GAP   = 2,
  parameter int BLANK = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] din_i,
  input  logic         rd_i,
  input  logic         switch_i,
  output logic [W-1:0] data_o,
  output logic         dav_o
);

  localparam int GW = $clog2(GAP + 1);
  localparam int BW = $clog2(BLANK + 1);

  logic [W-1:0]  data_q, shadow_q;
  logic          dav_q, pend_q, rd_q;
  logic [GW-1:0] gap_q;
  logic [BW-1:0] blank_q;
  logic          blank, rd_end;

  assign blank  = switch_i | (blank_q != '0);
  assign rd_end = rd_q & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      shadow_q <= '0;
      dav_q    <= 1'b0;
      pend_q   <= 1'b0;
      rd_q     <= 1'b0;
      gap_q    <= '0;
      blank_q  <= '0;
    end else begin
      rd_q <= rd_i;
      if (switch_i)           blank_q <= BW'(BLANK - 1);
      else if (blank_q != '0) blank_q <= blank_q - 1'b1;

      if (blank) begin
        // source change: marker wiped, in-flight captures dropped
        dav_q  <= 1'b0;
        pend_q <= 1'b0;
        gap_q  <= '0;
      end else if (rd_i) begin
        if (cap_i) begin
          pend_q   <= 1'b1;
          shadow_q <= din_i;
        end
      end else if (rd_end) begin
        dav_q  <= 1'b0;
        pend_q <= 1'b0;
        if (cap_i || pend_q) begin
          data_q <= cap_i ? din_i : shadow_q;
          gap_q  <= GW'(GAP);
        end
      end else if (gap_q != '0) begin
        gap_q <= gap_q - 1'b1;
        if (cap_i)              data_q <= din_i;
        if (gap_q == GW'(1))    dav_q  <= 1'b1;
      end else if (cap_i) begin
        data_q <= din_i;
        dav_q  <= 1'b1;
      end
    end
  end

  assign data_o = data_q;
  assign dav_o  = dav_q;

endmodule

// File: rtl/dav_capture_port.sv
module dav_capture_port
  import dcp_pkg::*;
#(
  parameter int NUM_CH       = 16,
  parameter int TICK_DIV     = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int GAP_CYCLES   = 2,
  parameter int BLANK_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] din_i,
  input  logic              xtrig_ni,
  input  logic              src_ext_i,
  input  logic              irq_en_i,
  input  logic              rd_i,
  output logic [NUM_CH-1:0] data_o,
  output logic              dav_o,
  output logic              irq_o
);

  cap_src_e src_sel, src_q;
  logic     ext_fall, int_tick, cap, sw_edge;

  assign src_sel = cap_src_e'(src_ext_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= SRC_INT;
    else         src_q <= src_sel;
  end

  assign sw_edge = (src_sel == SRC_EXT) && (src_q == SRC_INT);

  dcp_trig_sync #(.STAGES(SYNC_STAGES)) i_trig_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_ni(xtrig_ni),
    .fall_o (ext_fall)
  );

  dcp_tick_gen #(.DIV(TICK_DIV)) i_tick_gen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(int_tick)
  );

  assign cap = (src_sel == SRC_EXT) ? ext_fall : int_tick;

  dcp_marker_ctl #(
    .W    (NUM_CH),
    .GAP  (GAP_CYCLES),
    .BLANK(BLANK_CYCLES)
  ) i_marker_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .din_i   (din_i),
    .rd_i    (rd_i),
    .switch_i(sw_edge),
    .data_o  (data_o),
    .dav_o   (dav_o)
  );

  assign irq_o = irq_en_i & dav_o;

endmodule

// File: rtl/dcp_checker.sv
module dcp_checker #(
  parameter int NUM_CH = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              src_ext_i,
  input logic              irq_en_i,
  input logic [NUM_CH-1:0] data_o,
  input logic              dav_o,
  input logic              irq_o
);

  a_r7_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && dav_o));

  a_r7_irq_follows_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && dav_o) |-> irq_o);

  a_r4_read_end_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_i) && !rd_i) |=> !dav_o);

  a_r5_data_held_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i) |-> $stable(data_o));

  a_r5_no_post_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i) |-> !$rose(dav_o));

  a_r6_switch_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ext_i && !$past(src_ext_i)) |=> !dav_o);

endmodule

bind dav_capture_port dcp_checker #(.NUM_CH(NUM_CH)) i_dcp_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_i     (rd_i),
  .src_ext_i(src_ext_i),
  .irq_en_i (irq_en_i),
  .data_o   (data_o),
  .dav_o    (dav_o),
  .irq_o    (irq_o)
);

// File: tb/test_dav_capture_port.sv
`timescale 1ns/1ps
module test_dav_capture_port;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] din_i = '0;
  logic         xtrig_ni = 1'b1;
  logic         src_ext_i = 1'b0;
  logic         irq_en_i = 1'b0;
  logic         rd_i = 1'b0;
  logic [W-1:0] data_o;
  logic         dav_o, irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit sb_on    = 1'b0;
  logic dav_seen = 1'b0;
  logic [W-1:0] exp_q[$];

  always #10 clk = ~clk;

  dav_capture_port i_dav_capture_port (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .din_i    (din_i),
    .xtrig_ni (xtrig_ni),
    .src_ext_i(src_ext_i),
    .irq_en_i (irq_en_i),
    .rd_i     (rd_i),
    .data_o   (data_o),
    .dav_o    (dav_o),
    .irq_o    (irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // scoreboard monitor: every new posting must carry the oldest expected value
  always @(negedge clk) begin
    if (rst_ni && sb_on && dav_o && !dav_seen) begin
      if (exp_q.size() == 0) chk("R3 unexpected posting", 32'(dav_o), 32'd0);
      else                   chk("R3/R5 posted data", 32'(data_o), 32'(exp_q.pop_front()));
    end
    dav_seen = dav_o;
  end

  // driver: external capture, value pushed to the scoreboard
  task automatic ext_capture(logic [W-1:0] v, bit lat);
    din_i = v;
    xtrig_ni = 1'b0;
    exp_q.push_back(v);
    if (lat) begin
      @(negedge clk); chk("R3 latency edge1", 32'(dav_o), 32'd0);
      @(negedge clk); chk("R3 latency edge2", 32'(dav_o), 32'd0);
      @(negedge clk); chk("R3 latency edge3", 32'(dav_o), 32'd1);
      chk("R3 data", 32'(data_o), 32'(v));
    end else begin
      repeat (3) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    xtrig_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(logic [W-1:0] exp_data);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    @(negedge clk);
    chk("R4 marker cleared", 32'(dav_o), 32'd0);
    chk("R4 data kept", 32'(data_o), 32'(exp_data));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dav in reset", 32'(dav_o), 32'd0);
    chk("R1 irq in reset", 32'(irq_o), 32'd0);
    chk("R1 data in reset", 32'(data_o), 32'd0);
    din_i = 16'h1234;
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 dav after release", 32'(dav_o), 32'd0);

    // R2 internal tick
    repeat (19) @(negedge clk);
    chk("R2 internal capture dav", 32'(dav_o), 32'd1);
    chk("R2 internal capture data", 32'(data_o), 32'h1234);
    chk("R7 irq disabled", 32'(irq_o), 32'd0);
    irq_en_i = 1'b1;
    @(negedge clk);
    chk("R7 irq enabled", 32'(irq_o), 32'd1);
    din_i = 16'h5678;
    repeat (17) @(negedge clk);
    chk("R2 periodic resample", 32'(data_o), 32'h5678);

    // R6 switch to external with a trigger racing the switch
    din_i = 16'hC0DE;
    src_ext_i = 1'b1;
    xtrig_ni = 1'b0;
    @(negedge clk);
    chk("R6 switch clears marker", 32'(dav_o), 32'd0);
    chk("R7 irq follows cleared marker", 32'(irq_o), 32'd0);
    repeat (8) @(negedge clk);
    chk("R6 racing capture dropped dav", 32'(dav_o), 32'd0);
    chk("R6 racing capture dropped data", 32'(data_o), 32'h5678);
    xtrig_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R3 / R4 external captures
    sb_on = 1'b1;
    ext_capture(16'hA5A5, 1'b1);
    do_read(16'hA5A5);
    ext_capture(16'h0F0F, 1'b1);
    do_read(16'h0F0F);

    // R5 capture during a read
    ext_capture(16'h1111, 1'b1);
    rd_i = 1'b1;
    ext_capture(16'h2222, 1'b0);
    chk("R5 marker held in read", 32'(dav_o), 32'd1);
    chk("R5 data held in read", 32'(data_o), 32'h1111);
    rd_i = 1'b0;
    @(negedge clk); chk("R5 gap cycle 1", 32'(dav_o), 32'd0);
    @(negedge clk); chk("R5 gap cycle 2", 32'(dav_o), 32'd0);
    @(negedge clk); chk("R5 reposted", 32'(dav_o), 32'd1);
    chk("R5 queued data", 32'(data_o), 32'h2222);
    repeat (20) @(negedge clk);
    chk("R5 repost retained", 32'(dav_o), 32'd1);
    do_read(16'h2222);

    // R8 trigger held low
    din_i = 16'h3C3C;
    xtrig_ni = 1'b0;
    exp_q.push_back(16'h3C3C);
    repeat (5) @(negedge clk);
    chk("R8 first capture", 32'(dav_o), 32'd1);
    do_read(16'h3C3C);
    repeat (10) @(negedge clk);
    chk("R8 no recapture while low", 32'(dav_o), 32'd0);
    xtrig_ni = 1'b1;
    repeat (3) @(negedge clk);

    chk("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule